// File: doc/BRIEF.md
# Double-Buffered SPI Serial Port

This block is a byte-wide SPI port for a small processor subsystem. It can be the master, generating the serial clock from the system clock, or a slave that follows a clock arriving on a pin. Software sees three registers on a simple synchronous bus: a data register, a configuration register and a status register. The single shift register inside the block is never visible. Writing the data register loads the shift register. Reading the data register returns the last byte received.

Reception is double-buffered. When a byte has been fully shifted in, it is copied into a holding buffer. The next byte can then start while software has not yet fetched the previous one. Status bits report a waiting byte, a rejected write and a lost byte. A single interrupt line stays asserted until software clears it.

Configuration covers five things:
- the clock idle level;
- which clock edge moves the output data;
- whether input is sampled mid-bit or at the very end of the bit (master only);
- a three-way master clock divider;
- an optional slave-select gate (slave only).

Top module: `spi_port`

## Requirements
- R1: After reset, the three registers read as follows:
  - configuration reads 0, which selects slave mode with the select gate off;
  - status reads 0;
  - the data buffer reads 0.
  After reset `irq` is 0 and `sck_oe` is 0.
- R2: Master mode is selected with configuration bit 0 = 1. While idle, a write to the data register (address 0) starts one transfer of 8 bits, most significant bit first on `sdo`. Configuration bits [5:4] select the SCK period: 00 gives 4 system clocks, 01 gives 16, and 10 or 11 give 64. After the transfer SCK rests at its idle level.
- R3: When the eighth bit has been taken in, the received byte is placed in the buffer. Status bit 0 (full) and status bit 3 (interrupt) are both set. The `irq` pin follows status bit 3.
- R4: A read of address 0 clears the full bit.
- R5: A write to address 0 while a transfer is active (status bit 4 = 1) does not reach the shift register, and the byte on the line is unchanged. It sets status bit 1 (collision). That bit stays set until software writes status (address 2) with bit 1 = 0; writing bit 1 = 1 leaves it set.
- R6: If a byte completes while the full bit is still set, the buffer takes the new byte and status bit 2 (overflow) is set. The overflow bit clears only by a status write with bit 2 = 0.
- R7: The interrupt bit stays set until a status write with bit 3 = 0.
- R8: Configuration bit 1 sets the SCK idle level. Configuration bit 2 selects which edge moves the output data: 0 moves it on the return-to-idle edge, 1 moves it on the leaving-idle edge. All four combinations transfer data correctly.
- R9: Configuration bit 3 sets the master sampling point:
  - 0 samples `sdi` on the SCK edge opposite to the output edge (mid-bit);
  - 1 samples it at the output edge that ends the bit.
- R10: In slave mode (configuration bit 0 = 0):
  - `sck_oe` is 0;
  - `sck_i` and `sdi` pass through two-flop synchronizers, and edges are taken from the synchronized clock;
  - bytes are received and sent under the same idle-level and edge settings as in master mode.
- R11: Configuration bit 6 enables the slave-select gate. With it set in slave mode, `ss_n` = 1 holds `sdo_oe` at 0 and discards any partial byte by resetting the bit count. With bit 6 clear, `ss_n` has no effect and `sdo_oe` is 1.
- R12: The register map is as follows:
  - address 1 reads back configuration bits [6:0];
  - address 2 reads status as {busy, interrupt, overflow, collision, full} in bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 data, 1 configuration, 2 status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data read) |
| wdata | input | W | Write data |
| rdata | output | W | Read data for the selected register |
| irq | output | 1 | Sticky interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable (master mode) |
| sck_i | input | 1 | Serial clock input for slave mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
In master mode, let H be the half-period, which is 2, 8 or 32 clocks. The SCK edges come every H clocks, starting H clocks after the clock edge that accepts the data write. The full and interrupt bits rise H clocks after the sixteenth SCK edge, so 17H clocks after the write.

In slave mode the flags rise on the third rising clock edge after the pin edge that ends the byte. That delay is two synchronizer stages plus one edge-detect stage. Register reads are combinational.

The bench therefore:
- follows the master SCK edge by edge;
- waits H plus three clocks after the last edge before reading;
- waits five clocks after the last slave clock edge;
- samples outputs and read data at falling edges, never at the active edge.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W     = 8,
  parameter int HALF0 = 2,
  parameter int HALF1 = 8,
  parameter int HALF2 = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         sck_i,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe,
  input  logic         ss_n
);
  localparam int KW = $clog2(2*W+1);
  localparam int BW = $clog2(W+1);
  localparam int HW = $clog2(HALF2+1);
  localparam logic [KW-1:0] KEND = KW'(2*W);
  localparam logic [BW-1:0] NFULL = BW'(W);
  localparam logic [BW-1:0] NLAST = BW'(W-1);
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

  logic [6:0]    ctrl;
  logic [W-1:0]  sr, buf_q;
  logic          latch, full, wcol, ovf, irq_f;
  logic          mbusy, sck_q;
  logic [KW-1:0] k;
  logic [HW-1:0] cnt, half;
  logic [BW-1:0] scnt;
  logic [2:0]    sck_s;
  logic [1:0]    sdi_s, ss_s;

  wire master   = ctrl[0];
  wire cpol     = ctrl[1];
  wire lead_out = ctrl[2];
  wire late     = ctrl[3];
  wire ss_en    = ctrl[6];

  wire wr_data = wr_en && addr == A_DATA;
  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_stat = wr_en && addr == A_STAT;
  wire rd_data = rd_en && addr == A_DATA;

  always_comb
    case (ctrl[5:4])
      2'd0:    half = HW'(HALF0);
      2'd1:    half = HW'(HALF1);
      default: half = HW'(HALF2);
    endcase

  wire tick   = mbusy && cnt == half - HW'(1);
  wire m_samp = tick && k < KEND && (k[0] == lead_out);
  wire m_shft = tick && k != '0 && (k[0] != lead_out);
  wire m_done = tick && k == KEND;

  wire ss_idle = ss_en && ss_s[1];
  wire s_act   = !master && !ss_idle;
  wire s_rise  = sck_s[1] && !sck_s[2];
  wire s_fall  = !sck_s[1] && sck_s[2];
  wire s_lead  = cpol ? s_fall : s_rise;
  wire s_trail = cpol ? s_rise : s_fall;
  wire s_samp  = s_act && (lead_out ? s_trail : s_lead);
  wire s_shft  = s_act && (lead_out ? s_lead : s_trail) && scnt != '0;
  wire s_last  = lead_out && s_samp && scnt == NLAST;
  wire s_done  = lead_out ? s_last : (s_shft && scnt == NFULL);

  wire busy     = master ? mbusy : (scnt != '0);
  wire samp_en  = master ? m_samp : s_samp;
  wire shift_en = master ? m_shft : (s_shft || s_last);
  wire done     = master ? m_done : s_done;
  wire sbit     = master ? (late ? sdi : latch) : (s_last ? sdi_s[1] : latch);
  wire [W-1:0] sr_nx  = {sr[W-2:0], sbit};
  wire [W-1:0] rx_val = shift_en ? sr_nx : sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      sdi_s <= '0;
      ss_s  <= 2'b11;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      sdi_s <= {sdi_s[0], sdi};
      ss_s  <= {ss_s[0], ss_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mbusy <= 1'b0;
      k     <= '0;
      cnt   <= '0;
      sck_q <= 1'b0;
    end else begin
      if (wr_data && !busy && master) begin
        mbusy <= 1'b1;
        k     <= '0;
        cnt   <= '0;
      end else if (mbusy) begin
        if (tick) begin
          cnt <= '0;
          if (m_done) mbusy <= 1'b0;
          else        k <= k + KW'(1);
        end else begin
          cnt <= cnt + HW'(1);
        end
      end
      if (!mbusy)                 sck_q <= cpol;
      else if (tick && k < KEND)  sck_q <= ~sck_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scnt <= '0;
    else if (master || ss_idle || s_done) scnt <= '0;
    else if (s_samp) scnt <= scnt + BW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr    <= '0;
      latch <= 1'b0;
    end else begin
      if (samp_en) latch <= master ? sdi : sdi_s[1];
      if (wr_data && !busy) sr <= wdata;
      else if (shift_en)    sr <= sr_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl  <= '0;
      buf_q <= '0;
      full  <= 1'b0;
      wcol  <= 1'b0;
      ovf   <= 1'b0;
      irq_f <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wdata[6:0];
      if (done) buf_q <= rx_val;
      if (done)         full <= 1'b1;
      else if (rd_data) full <= 1'b0;
      if (done && full)              ovf <= 1'b1;
      else if (wr_stat && !wdata[2]) ovf <= 1'b0;
      if (done)                      irq_f <= 1'b1;
      else if (wr_stat && !wdata[3]) irq_f <= 1'b0;
      if (wr_data && busy)           wcol <= 1'b1;
      else if (wr_stat && !wdata[1]) wcol <= 1'b0;
    end

  always_comb
    case (addr)
      A_DATA:  rdata = buf_q;
      A_CTRL:  rdata = W'({1'b0, ctrl});
      A_STAT:  rdata = W'({busy, irq_f, ovf, wcol, full});
      default: rdata = '0;
    endcase

  assign irq    = irq_f;
  assign sck_o  = sck_q;
  assign sck_oe = master;
  assign sdo    = sr[W-1];
  assign sdo_oe = master || !ss_idle;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !mbusy && $past(!mbusy) && $stable(cpol)) |-> sck_o == cpol); // R2
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mbusy |-> k <= KEND); // R2
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> full && irq); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !full); // R4
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol); // R5
  AST_WCOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !wr_stat) |=> wcol); // R5
  AST_WCOL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy && !shift_en) |=> sr == $past(sr)); // R5
  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full) |=> ovf); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_stat) |=> irq); // R7
  AST_SLAVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= NFULL); // R10
  AST_SS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && ss_idle) |=> scnt == '0); // R11
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, sck_o, sck_oe, sdo, sdo_oe;
  logic sck_i = 0, sdi = 0, ss_n = 1;
  logic [7:0] cfg = 0;
  logic [7:0] exp_q[$];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_port uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic setcfg(input logic [7:0] c);
    wr(1, c); cfg = c;
    repeat (2) @(negedge clk);
  endtask

  task automatic collect(input string tag);
    logic [7:0] got, exp;
    rd(0, got);
    exp = exp_q.pop_front();
    check(tag, got, exp);
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] sb, input bit skew,
                        output logic [7:0] mosi, output int per);
    int hh, ii, oi;
    time t0, t2;
    logic lead, is_in;
    hh = (cfg[5:4] == 0) ? 2 : (cfg[5:4] == 1) ? 8 : 32;
    ii = 0; oi = 0; t0 = 0; t2 = 0; mosi = 0;
    if (!skew && !cfg[2]) begin sdi = sb[7]; oi = 1; end
    else sdi = 0;
    wr(0, tx);
    for (int e = 0; e < 16; e++) begin
      @(sck_o);
      if (e == 0) t0 = $time;
      if (e == 2) t2 = $time;
      lead  = (sck_o != cfg[1]);
      is_in = lead ^ cfg[2];
      if (is_in) begin
        mosi[7-ii] = sdo;
        if (skew) sdi = sb[7-ii];
        ii++;
      end else if (!skew && oi < 8) begin
        sdi = sb[7-oi];
        oi++;
      end
    end
    per = int'((t2 - t0) / 20);
    repeat (hh + 3) @(negedge clk);
  endtask

  task automatic s_xfer(input logic [7:0] mb, input int nbits, output logic [7:0] so);
    so = 0;
    for (int i = 0; i < nbits; i++) begin
      if (!cfg[2]) begin
        sdi = mb[7-i];
        repeat (8) @(negedge clk);
        so[7-i] = sdo;
        sck_i = ~cfg[1];
        repeat (8) @(negedge clk);
        sck_i = cfg[1];
      end else begin
        repeat (8) @(negedge clk);
        sck_i = ~cfg[1];
        sdi = mb[7-i];
        repeat (7) @(negedge clk);
        so[7-i] = sdo;
        @(negedge clk);
        sck_i = cfg[1];
      end
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, mo;
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2, v); check("R1 status after reset", v, 8'h00);
    rd(1, v); check("R1 config after reset", v, 8'h00);
    rd(0, v); check("R1 buffer after reset", v, 8'h00);
    check("R1 irq after reset", irq, 0);
    check("R1 sck_oe after reset", sck_oe, 0);

    setcfg(8'h01);
    rd(1, v); check("R12 config readback", v, 8'h01);
    check("R2 sck_oe in master", sck_oe, 1);

    exp_q.push_back(8'h3C);
    m_xfer(8'hA5, 8'h3C, 0, mo, per);
    check("R2 mosi msb first", mo, 8'hA5);
    check("R2 period div4", per, 4);
    check("R2 sck back idle", sck_o, 0);
    check("R3 irq pin", irq, 1);
    rd(2, v); check("R3 R12 status full+irq", v, 8'h09);
    collect("R3 buffer byte");
    rd(2, v); check("R4 full cleared by read", v, 8'h08);
    wr(2, 8'h08); check("R7 irq kept by writing one", irq, 1);
    wr(2, 8'hF7); check("R7 irq cleared by writing zero", irq, 0);

    setcfg(8'h17);
    check("R8 idle high", sck_o, 1);
    exp_q.push_back(8'hC3);
    m_xfer(8'h5A, 8'hC3, 0, mo, per);
    check("R8 mosi cpol1 lead", mo, 8'h5A);
    check("R2 period div16", per, 16);
    check("R8 idle high after", sck_o, 1);
    collect("R8 rx cpol1 lead");
    wr(2, 8'h00);

    setcfg(8'h05);
    exp_q.push_back(8'h7E);
    m_xfer(8'h81, 8'h7E, 0, mo, per);
    check("R8 mosi cpol0 lead", mo, 8'h81);
    collect("R8 rx cpol0 lead");

    setcfg(8'h03);
    exp_q.push_back(8'hBD);
    m_xfer(8'h42, 8'hBD, 0, mo, per);
    check("R8 mosi cpol1 trail", mo, 8'h42);
    collect("R8 rx cpol1 trail");
    wr(2, 8'h00);

    setcfg(8'h29);
    exp_q.push_back(8'hD2);
    m_xfer(8'h0F, 8'hD2, 1, mo, per);
    check("R2 period div64", per, 64);
    collect("R9 late sample trail-out");

    setcfg(8'h0D);
    exp_q.push_back(8'h6B);
    m_xfer(8'hF0, 8'h6B, 1, mo, per);
    collect("R9 late sample lead-out");

    setcfg(8'h01);
    exp_q.push_back(8'h69);
    m_xfer(8'h00, 8'hD3, 1, mo, per);
    collect("R9 middle sample misses skewed data");
    wr(2, 8'h00);

    setcfg(8'h11);
    exp_q.push_back(8'h39);
    fork
      m_xfer(8'hC6, 8'h39, 0, mo, per);
      begin repeat (40) @(negedge clk); wr(0, 8'hFF); end
    join
    check("R5 line byte unchanged", mo, 8'hC6);
    rd(2, v); check("R5 collision flagged", v, 8'h0B);
    collect("R5 rx after collision");
    wr(2, 8'h02);
    rd(2, v); check("R5 collision sticky", v, 8'h02);
    wr(2, 8'h00);
    rd(2, v); check("R5 collision cleared", v, 8'h00);

    setcfg(8'h01);
    m_xfer(8'h11, 8'h44, 0, mo, per);
    m_xfer(8'h22, 8'h55, 0, mo, per);
    rd(2, v); check("R6 overflow flagged", v, 8'h0D);
    exp_q.push_back(8'h55);
    collect("R6 buffer holds newer byte");
    wr(2, 8'h04);
    rd(2, v); check("R6 overflow sticky", v, 8'h04);
    wr(2, 8'h00);

    setcfg(8'h40);
    check("R10 sck_oe off in slave", sck_oe, 0);
    check("R11 sdo off while deselected", sdo_oe, 0);
    wr(0, 8'h96);
    ss_n = 0;
    repeat (4) @(negedge clk);
    check("R11 sdo on when selected", sdo_oe, 1);
    exp_q.push_back(8'h69);
    s_xfer(8'h69, 8, mo);
    check("R10 slave sends", mo, 8'h96);
    rd(2, v); check("R10 slave status", v, 8'h09);
    collect("R10 slave receives");
    wr(2, 8'h00);

    wr(0, 8'hF0);
    s_xfer(8'hFF, 3, mo);
    ss_n = 1;
    repeat (4) @(negedge clk);
    rd(2, v); check("R11 partial byte dropped", v, 8'h00);
    check("R11 sdo off after deselect", sdo_oe, 0);
    wr(0, 8'hF0);
    ss_n = 0;
    repeat (4) @(negedge clk);
    exp_q.push_back(8'hA3);
    s_xfer(8'hA3, 8, mo);
    check("R11 aligned send after reselect", mo, 8'hF0);
    collect("R11 aligned receive after reselect");
    wr(2, 8'h00);

    ss_n = 1;
    sck_i = 1;
    repeat (4) @(negedge clk);
    setcfg(8'h46);
    wr(0, 8'h5C);
    ss_n = 0;
    repeat (4) @(negedge clk);
    exp_q.push_back(8'h3A);
    s_xfer(8'h3A, 8, mo);
    check("R8 R10 slave send cpol1 lead", mo, 8'h5C);
    collect("R8 R10 slave receive cpol1 lead");

    ss_n = 1;
    setcfg(8'h06);
    check("R11 gate off keeps sdo on", sdo_oe, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule